// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block moves one transmit frame from memory to a byte stream each time software asks it to. Software places 16-byte descriptors in a ring in memory. Each descriptor is four 32-bit little-endian words: status/length at offset 0, a tag word at offset 4, the buffer address low word at offset 8, and a high word at offset 12 that is assumed to be zero. Software then writes a trigger code to a byte-wide poll register. The engine reads the status word of the current descriptor. If hardware owns the descriptor and it holds a complete frame, the engine reads the buffer address, fetches the frame one 32-bit word at a time and emits it byte by byte on a valid/ready stream that carries a last flag.

When the last byte has been accepted, the engine writes the status word back with the ownership bit cleared and pulses `tx_ok`. It then moves its descriptor index forward. The index returns to zero after a descriptor that carries the end-of-ring bit. A descriptor that is not owned by hardware leaves the engine idle. A descriptor that is not a single complete frame raises `tx_err`.

The memory side is a simple request/acknowledge master. The request, write enable and address stay stable until `mem_ack` is sampled high, and read data is valid in the acknowledge cycle.

Top module: `txdp_engine`

## Requirements
- R1: A write with `cfg_sel`=0 loads the ring base from `cfg_wdata` with its low 8 bits forced to zero. Descriptor k is fetched at base + 16*k.
- R2: A write with `cfg_sel`=1 starts a transfer only if `cfg_wdata[7:0]` is 0x40 and the engine is idle. Any other code, and any poll that arrives while a transfer is in progress, is ignored and causes no memory request.
- R3: The status word (offset 0) is read first. If its bit 31 (ownership) is 0, the engine returns to idle. It then writes nothing, emits no byte, raises no pulse and keeps its index.
- R4: An owned descriptor whose status bit 29 (first segment) and bit 28 (last segment) are not both 1 gives a one-cycle `tx_err` pulse. It then gets no buffer access, no write-back and no byte output, and the index does not change.
- R5: For an accepted descriptor, the buffer address is read from offset 8 with its low 2 bits ignored. Exactly status[15:0] bytes are read as whole words from consecutive word addresses and emitted in little-endian order within each word: byte 0 is bits 7:0.
- R6: `tx_tlast` is 1 on the final byte of the frame and 0 on every other byte.
- R7: While `tx_tvalid` is 1 and `tx_tready` is 0, the stream data and last flag hold.
- R8: After the last byte is accepted, the status word is written back to offset 0 of the same descriptor with bit 31 cleared and every other bit unchanged.
- R9: `tx_ok` pulses for exactly one cycle, in the cycle after the write-back is acknowledged.
- R10: After a write-back, the index becomes 0 if status bit 30 (end of ring) was set. Otherwise it increments, modulo 2^IDX_W.
- R11: A memory request that is not acknowledged holds the request, the write enable and the address into the next cycle.
- R12: After reset the index is 0, and there is no memory request, no stream data and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects ring base, 1 selects poll register |
| cfg_wdata | input | ADDR_W | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | DATA_W | Read data |
| tx_tdata | output | 8 | Stream byte |
| tx_tvalid | output | 1 | Stream byte valid |
| tx_tlast | output | 1 | Final byte of frame |
| tx_tready | input | 1 | Stream sink ready |
| tx_ok | output | 1 | One-cycle completion pulse |
| tx_err | output | 1 | One-cycle malformed-descriptor pulse |

## Verification
The bench builds the engine with IDX_W=2, which gives a four-entry ring. With that setting, a run of frames without the end-of-ring bit wraps the index naturally, and the end-of-ring wrap can also be hit within a few frames. ADDR_W, DATA_W and LEN_W keep their defaults of 32, 32 and 16.

Random frame lengths cover every residue of the length modulo four, so the final partial word is exercised. Buffer addresses with non-zero low bits exercise the ignored address bits. Random acknowledge and ready stalls drive both hold rules.

// File: rtl/txdp_pkg.sv
package txdp_pkg;
    // status word bit positions, decoded by software and hardware alike
    localparam int OWN_BIT = 31;
    localparam int EOR_BIT = 30;
    localparam int FS_BIT  = 29;
    localparam int LS_BIT  = 28;

    localparam logic [7:0] POLL_CODE = 8'h40;
    localparam int BASE_ALIGN_W = 8;
    localparam int DESC_SHIFT   = 4;   // 16 bytes per descriptor
    localparam int BUF_WORD_OFS = 8;   // offset of buffer address word

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAT,
        ST_BUF,
        ST_DATA,
        ST_SEND,
        ST_WB
    } txdp_state_e;
endpackage

// File: rtl/txdp_cfg.sv
module txdp_cfg
    import txdp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              busy,
    output logic [ADDR_W-1:0] ring_base,
    output logic              poll_go
);
    logic [ADDR_W-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (cfg_we && !cfg_sel) begin
            base_d = {cfg_wdata[ADDR_W-1:BASE_ALIGN_W], {BASE_ALIGN_W{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign ring_base = base_q;
    assign poll_go   = cfg_we && cfg_sel && (cfg_wdata[7:0] == POLL_CODE) && !busy;
endmodule

// File: rtl/txdp_byteser.sv
module txdp_byteser #(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [DATA_W-1:0]           word,
    input  logic [$clog2(DATA_W/8+1)-1:0] nbytes,
    input  logic                        final_word,
    input  logic                        tready,
    output logic                        tvalid,
    output logic [7:0]                  tdata,
    output logic                        tlast,
    output logic                        empty
);
    localparam int NB = DATA_W / 8;
    localparam int CW = $clog2(NB + 1);
    localparam int SW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic [NB-1:0][7:0] bytes;
        logic [CW-1:0]      left;
        logic [SW-1:0]      sel;
        logic               fin;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.bytes = word;
            s_d.left  = nbytes;
            s_d.sel   = '0;
            s_d.fin   = final_word;
        end else if (tvalid && tready) begin
            s_d.left = s_q.left - CW'(1);
            s_d.sel  = s_q.sel + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tvalid = (s_q.left != '0);
    assign tdata  = s_q.bytes[s_q.sel];
    assign tlast  = s_q.fin && (s_q.left == CW'(1));
    assign empty  = (s_q.left == '0);
endmodule

// File: rtl/txdp_engine.sv
module txdp_engine
    import txdp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [7:0]        tx_tdata,
    output logic              tx_tvalid,
    output logic              tx_tlast,
    input  logic              tx_tready,
    output logic              tx_ok,
    output logic              tx_err
);
    localparam int NB = DATA_W / 8;
    localparam int CW = $clog2(NB + 1);
    localparam int AL = $clog2(NB);

    typedef struct packed {
        txdp_state_e       st;
        logic [IDX_W-1:0]  idx;
        logic [31:0]       stat;
        logic [ADDR_W-1:0] ptr;
        logic [LEN_W-1:0]  left;
        logic              ok;
        logic              err;
    } eng_t;

    eng_t r_d, r_q;

    logic [ADDR_W-1:0] ring_base;
    logic              poll_go;
    logic [ADDR_W-1:0] desc_addr;
    logic              ser_load;
    logic [CW-1:0]     ser_n;
    logic              ser_fin;
    logic              ser_empty;
    logic [31:0]       rd_stat;

    txdp_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .busy      (r_q.st != ST_IDLE),
        .ring_base (ring_base),
        .poll_go   (poll_go)
    );

    txdp_byteser #(.DATA_W(DATA_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ser_load),
        .word       (mem_rdata),
        .nbytes     (ser_n),
        .final_word (ser_fin),
        .tready     (tx_tready),
        .tvalid     (tx_tvalid),
        .tdata      (tx_tdata),
        .tlast      (tx_tlast),
        .empty      (ser_empty)
    );

    assign desc_addr = ring_base + (ADDR_W'(r_q.idx) << DESC_SHIFT);
    assign rd_stat   = mem_rdata[31:0];

    // memory master outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = DATA_W'(r_q.stat & ~(32'h1 << OWN_BIT));
        unique case (r_q.st)
            ST_STAT: mem_req = 1'b1;
            ST_BUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(BUF_WORD_OFS);
            end
            ST_DATA: begin
                mem_req  = 1'b1;
                mem_addr = r_q.ptr;
            end
            ST_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // sequencer next state
    always_comb begin
        r_d      = r_q;
        r_d.ok   = 1'b0;
        r_d.err  = 1'b0;
        ser_load = 1'b0;
        ser_n    = '0;
        ser_fin  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (poll_go) r_d.st = ST_STAT;
            end
            ST_STAT: begin
                if (mem_ack) begin
                    r_d.stat = rd_stat;
                    if (!rd_stat[OWN_BIT]) begin
                        r_d.st = ST_IDLE;
                    end else if (!(rd_stat[FS_BIT] && rd_stat[LS_BIT])) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.left = rd_stat[LEN_W-1:0];
                        r_d.st   = ST_BUF;
                    end
                end
            end
            ST_BUF: begin
                if (mem_ack) begin
                    r_d.ptr = ADDR_W'(mem_rdata) & ~ADDR_W'(NB - 1);
                    r_d.st  = (r_q.left == '0) ? ST_WB : ST_DATA;
                end
            end
            ST_DATA: begin
                if (mem_ack) begin
                    ser_load = 1'b1;
                    if (r_q.left > LEN_W'(NB)) begin
                        ser_n    = CW'(NB);
                        r_d.left = r_q.left - LEN_W'(NB);
                    end else begin
                        ser_n    = CW'(r_q.left);
                        ser_fin  = 1'b1;
                        r_d.left = '0;
                    end
                    r_d.ptr = r_q.ptr + ADDR_W'(NB);
                    r_d.st  = ST_SEND;
                end
            end
            ST_SEND: begin
                if (ser_empty) r_d.st = (r_q.left == '0) ? ST_WB : ST_DATA;
            end
            ST_WB: begin
                if (mem_ack) begin
                    r_d.ok  = 1'b1;
                    r_d.idx = r_q.stat[EOR_BIT] ? '0 : r_q.idx + IDX_W'(1);
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ok  = r_q.ok;
    assign tx_err = r_q.err;

    // AL used to document word alignment of buffer pointer
    if (AL < 0) begin : g_never
    end
endmodule

// File: rtl/txdp_checker.sv
module txdp_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [7:0]        tx_tdata,
    input logic              tx_tvalid,
    input logic              tx_tlast,
    input logic              tx_tready,
    input logic              tx_ok,
    input logic              tx_err
);
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11

    AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]); // R8

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R5

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast)); // R7

    AST_OK_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok |-> $past(mem_req && mem_we && mem_ack)); // R9

    AST_OK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok |=> !tx_ok); // R9

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |=> !tx_err); // R4

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ok && tx_err)); // R4
endmodule

bind txdp_engine txdp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_txdp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_tdata  (tx_tdata),
    .tx_tvalid (tx_tvalid),
    .tx_tlast  (tx_tlast),
    .tx_tready (tx_tready),
    .tx_ok     (tx_ok),
    .tx_err    (tx_err)
);

// File: tb/test_txdp_engine.sv
module test_txdp_engine;
    localparam int IDX_W = 2;
    localparam int WDOG  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  tx_tdata;
    logic        tx_tvalid, tx_tlast;
    logic        tx_tready = 1'b0;
    logic        tx_ok, tx_err;

    always #2 clk = ~clk;

    txdp_engine #(.ADDR_W(32), .DATA_W(32), .IDX_W(IDX_W), .LEN_W(16)) i_txdp_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tlast(tx_tlast), .tx_tready(tx_tready),
        .tx_ok(tx_ok), .tx_err(tx_err)
    );

    logic [31:0] mem [0:1023];
    logic [31:0] rd_log [0:255];
    logic [7:0]  cap_b [0:511];
    logic        cap_l [0:511];
    int rd_n, wr_n, cap_n, ok_n, err_n, cyc;
    logic [31:0] wr_addr, wr_data;
    int nchk, nfail;
    logic [31:0] base_exp;
    int exp_idx;

    function automatic void summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!cond) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one cycle of the memory and stream sink models, run at the falling edge
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > WDOG) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WDOG);
            summary();
            $finish;
        end
        if (!rst_n) begin
            mem_ack   = 1'b0;
            tx_tready = 1'b0;
        end else begin
            mem_ack = mem_req && ($urandom_range(0, 2) != 0);
            if (mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr[11:2]] = mem_wdata;
                    wr_n++;
                    wr_addr = mem_addr;
                    wr_data = mem_wdata;
                end else begin
                    mem_rdata = mem[mem_addr[11:2]];
                    if (rd_n < 256) rd_log[rd_n] = mem_addr;
                    rd_n++;
                end
            end
            tx_tready = ($urandom_range(0, 3) != 0);
            if (tx_tvalid && tx_tready && cap_n < 512) begin
                cap_b[cap_n] = tx_tdata;
                cap_l[cap_n] = tx_tlast;
                cap_n++;
            end
            if (tx_ok)  ok_n++;
            if (tx_err) err_n++;
        end
    endtask

    task automatic cfg_write(input bit sel, input logic [31:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        tick();
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    endtask

    task automatic clear_logs();
        rd_n = 0; wr_n = 0; cap_n = 0;
    endtask

    // status = own,eor,fs,ls | random bits 27:16 | length
    task automatic make_desc(input int idx, input int len, input bit own, input bit eor,
                             input bit fs, input bit ls);
        logic [31:0] st, bufa;
        int d;
        st = {own, eor, fs, ls, 12'($urandom), 16'(len)};
        bufa = 32'h400 + 32'(idx) * 32'h100 + 32'($urandom_range(0, 3));
        d = (int'(base_exp) >> 2) + idx * 4;
        mem[d]     = st;
        mem[d + 1] = $urandom;
        mem[d + 2] = bufa;
        mem[d + 3] = 32'h0;
        for (int w = 0; w < 64; w++) mem[(int'(bufa) >> 2) + w] = $urandom;
    endtask

    function automatic logic [7:0] exp_byte(input logic [31:0] bufa, input int i);
        logic [31:0] w;
        w = mem[int'(bufa[11:2]) + i / 4];
        return w[8*(i%4) +: 8];
    endfunction

    task automatic do_frame(input bit extra_poll);
        logic [31:0] daddr, st, bufa;
        int ok0, err0, len, mism, first_bad, lastflags, words;
        bit good;
        daddr = base_exp + 32'(exp_idx) * 32'd16;
        st    = mem[daddr[11:2]];
        bufa  = mem[daddr[11:2] + 2];
        len   = int'(st[15:0]);
        good  = st[31] && st[29] && st[28];
        ok0 = ok_n; err0 = err_n;
        clear_logs();
        cfg_write(1'b1, 32'h40);
        for (int k = 0; k < 3000; k++) begin
            if (ok_n != ok0 || err_n != err0) break;
            if (!st[31] && k >= 30) break;
            if (extra_poll && k == 5) cfg_write(1'b1, 32'h40);
            else tick();
        end
        for (int k = 0; k < 20; k++) tick();

        check(rd_n >= 1 && rd_log[0] == daddr, "R10", "status fetch address", rd_log[0], daddr);
        if (!st[31]) begin
            check(rd_n == 1 && wr_n == 0 && cap_n == 0, "R3", "activity on unowned desc",
                  32'(rd_n + wr_n + cap_n), 32'd1);
            check(ok_n == ok0 && err_n == err0, "R3", "pulse on unowned desc",
                  32'(ok_n + err_n), 32'(ok0 + err0));
        end else if (!good) begin
            check(err_n == err0 + 1, "R4", "tx_err pulse count", 32'(err_n - err0), 32'd1);
            check(rd_n == 1 && wr_n == 0 && cap_n == 0 && ok_n == ok0, "R4",
                  "activity on rejected desc", 32'(rd_n + wr_n + cap_n), 32'd1);
        end else begin
            check(rd_n >= 2 && rd_log[1] == daddr + 32'd8, "R1", "buffer pointer fetch address",
                  rd_log[1], daddr + 32'd8);
            check(cap_n == len, "R5", "byte count", 32'(cap_n), 32'(len));
            mism = 0; first_bad = -1; lastflags = 0;
            for (int i = 0; i < cap_n && i < len; i++) begin
                if (cap_b[i] !== exp_byte(bufa, i)) begin
                    mism++;
                    if (first_bad < 0) first_bad = i;
                end
                if (cap_l[i] !== (i == len - 1)) lastflags++;
            end
            check(mism == 0, "R5", "byte content mismatches",
                  first_bad < 0 ? 32'h0 : 32'(cap_b[first_bad]),
                  first_bad < 0 ? 32'h0 : 32'(exp_byte(bufa, first_bad)));
            check(lastflags == 0, "R6", "misplaced last flags", 32'(lastflags), 32'd0);
            words = (len + 3) / 4;
            check(rd_n == 2 + words, "R2", "read count (no extra transfer)",
                  32'(rd_n), 32'(2 + words));
            check(wr_n == 1 && wr_addr == daddr, "R8", "write-back address", wr_addr, daddr);
            check(wr_data == (st & 32'h7fff_ffff), "R8", "write-back value",
                  wr_data, st & 32'h7fff_ffff);
            check(ok_n == ok0 + 1 && err_n == err0, "R9", "tx_ok pulse count",
                  32'(ok_n - ok0), 32'd1);
            exp_idx = st[30] ? 0 : (exp_idx + 1) % (1 << IDX_W);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        nchk = 0; nfail = 0; cyc = 0; ok_n = 0; err_n = 0;
        clear_logs();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 5; i++) tick();
        rst_n = 1'b1;
        tick();
        check(!mem_req && !tx_tvalid && !tx_ok && !tx_err, "R12", "idle after reset",
              {28'h0, mem_req, tx_tvalid, tx_ok, tx_err}, 32'h0);

        // R1: base written with low bits set, stored aligned
        cfg_write(1'b0, 32'h0000_01A7);
        base_exp = 32'h100;
        exp_idx  = 0;

        // R2: wrong poll code ignored
        make_desc(0, 60, 1, 0, 1, 1);
        clear_logs();
        cfg_write(1'b1, 32'h41);
        for (int k = 0; k < 15; k++) tick();
        check(rd_n == 0 && cap_n == 0, "R2", "reads after wrong poll code", 32'(rd_n), 32'd0);

        // R3: unowned descriptor
        make_desc(0, 60, 0, 0, 1, 1);
        do_frame(1'b0);
        // R4: first segment only, then last segment only
        make_desc(0, 60, 1, 0, 1, 0);
        do_frame(1'b0);
        make_desc(0, 64, 1, 0, 0, 1);
        do_frame(1'b0);
        // R12: index still 0, plain 60-byte frame
        make_desc(0, 60, 1, 0, 1, 1);
        do_frame(1'b0);
        // odd length and poll while busy (R2)
        make_desc(1, 61, 1, 0, 1, 1);
        do_frame(1'b1);
        // R10: natural wrap through indices 2,3 then 0
        make_desc(2, 62, 1, 0, 1, 1);
        do_frame(1'b0);
        make_desc(3, 63, 1, 0, 1, 1);
        do_frame(1'b0);
        check(exp_idx == 0, "R10", "bench index after modulo wrap", 32'(exp_idx), 32'd0);
        // R10: end-of-ring at index 1
        make_desc(0, 70, 1, 0, 1, 1);
        do_frame(1'b0);
        make_desc(1, 90, 1, 1, 1, 1);
        do_frame(1'b0);
        // random frames
        for (int n = 0; n < 24; n++) begin
            make_desc(exp_idx, $urandom_range(60, 200), 1, ($urandom_range(0, 3) == 0),
                      1, 1);
            do_frame($urandom_range(0, 3) == 0);
        end

        summary();
        $finish;
    end
endmodule